// File: doc/BRIEF.md
# Priority-select one-hot index scatter

This block picks one winning lane out of a set of request lanes and turns that lane's index field into a one-hot vector. Each lane brings a valid bit and a lane word. A fixed bit range inside the lane word, at the same offset in every lane, holds the index field. The winner is the valid lane with the highest fixed priority. The output has exactly the bit set whose position equals the winner's index. When no lane requests, the output is zero.

The block is purely combinational. Pairs of (valid, index) records are merged in a balanced tree, so the select path is logarithmic in the lane count. A binary decoder that grows the output one index bit at a time then expands only the winning index. Parameters set the lane count, the output width, the lane word width, the field offset and the priority direction. Typical uses are grant-to-target steering and picking a destination from a list of requesters.

Top module: `prio_onehot_scatter`

## Requirements
- R1: When every bit of `valid_i` is 0, all `OUT_W` bits of `onehot_o` are 0.
- R2: When at least one bit of `valid_i` is 1, exactly one bit of `onehot_o` is 1.
- R3: With `HIGH_FIRST` = 0, the winner is the valid lane with the smallest lane number.
- R4: With `HIGH_FIRST` = 1, the winner is the valid lane with the largest lane number.
- R5: Lane k's word is `data_i[k*LANE_W +: LANE_W]`. Its index field is bits `[FIELD_LO +: log2(OUT_W)]` of that word, read as an unsigned number. The bit set in `onehot_o` is the one at that number's position for the winning lane.
- R6: Changing the lane-word bits outside the index field, or the words of lanes that do not win, leaves `onehot_o` unchanged.
- R7: `onehot_o` follows the inputs with no clock and no stored state. A new input value is reflected without any clock edge.
- R8: Lane counts that are not a power of two, within 4 to 64, resolve correctly. So does a packed layout where `LANE_W` equals the field width and `FIELD_LO` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | N_LANES | Request bit per lane; bit k belongs to lane k |
| data_i | input | N_LANES*LANE_W | Flat lane words; lane k occupies bits [k*LANE_W +: LANE_W] |
| onehot_o | output | OUT_W | One-hot position chosen by the winning lane's index field, or zero |

## Verification
Priority resolution and index decoding act on the same input vector. A decode error and a wrong winner are therefore told apart only when several lanes request at once and carry different index fields. The bench provokes this with adjacent pairs that hold distinct fields, with full and partial prefix and suffix masks, and with random masks and random fields. Every output is compared against a loop model that scans the lanes in the configured direction. Two instances run side by side: one low-first with a sub-slice field and a power-of-two lane count, and one high-first with a packed field and five lanes. Together they cover both directions and both field layouts in the same stimulus.

// File: rtl/prio_scatter_pkg.sv
package prio_scatter_pkg;

    // Number of merge levels for a lane count (ceil(log2(n)), 0 for n <= 1).
    function automatic int tree_levels(input int n);
        int lv;
        lv = 0;
        while ((1 << lv) < n) lv++;
        return lv;
    endfunction

    // True when x is a nonzero power of two.
    function automatic bit is_pow2(input int x);
        return (x > 0) && ((x & (x - 1)) == 0);
    endfunction

endpackage

// File: rtl/ps_lane_unpack.sv
module ps_lane_unpack #(
    parameter int N_LANES    = 8,
    parameter int LANE_W     = 6,
    parameter int FIELD_LO   = 1,
    parameter int IDX_W      = 4,
    parameter bit HIGH_FIRST = 1'b0
) (
    input  logic [N_LANES-1:0]        valid_i,
    input  logic [N_LANES*LANE_W-1:0] data_i,
    output logic [N_LANES-1:0]        ord_valid_o,
    output logic [N_LANES*IDX_W-1:0]  ord_idx_o
);
    // Position 0 of the ordered view always carries the highest priority lane.
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        localparam int SRC = HIGH_FIRST ? (N_LANES - 1 - k) : k;
        assign ord_valid_o[k]              = valid_i[SRC];
        assign ord_idx_o[k*IDX_W +: IDX_W] = data_i[SRC*LANE_W + FIELD_LO +: IDX_W];
    end

    // Bits outside the index fields are intentionally not consumed.
    logic unused_bits;
    assign unused_bits = ^data_i;
endmodule

// File: rtl/ps_merge_node.sv
module ps_merge_node #(
    parameter int IDX_W = 4
) (
    input  logic             hi_valid_i,
    input  logic [IDX_W-1:0] hi_idx_i,
    input  logic             lo_valid_i,
    input  logic [IDX_W-1:0] lo_idx_i,
    output logic             out_valid_o,
    output logic [IDX_W-1:0] out_idx_o
);
    logic take_lo_d;

    always_comb begin
        take_lo_d   = ~hi_valid_i & lo_valid_i;
        out_valid_o = hi_valid_i | lo_valid_i;
        out_idx_o   = take_lo_d ? lo_idx_i : hi_idx_i;
    end
endmodule

// File: rtl/ps_merge_tree.sv
module ps_merge_tree
    import prio_scatter_pkg::*;
#(
    parameter int N_LANES = 8,
    parameter int IDX_W   = 4
) (
    input  logic [N_LANES-1:0]       ord_valid_i,
    input  logic [N_LANES*IDX_W-1:0] ord_idx_i,
    output logic                     root_valid_o,
    output logic [IDX_W-1:0]         root_idx_o
);
    localparam int LEVELS = tree_levels(N_LANES);
    localparam int PAD    = 1 << LEVELS;

    // Level 0 holds the padded leaves; level j holds PAD >> j merged records.
    // Left record of each pair (even slot) has the higher priority.
    for (genvar j = 0; j <= LEVELS; j++) begin : g_lvl
        localparam int CNT = PAD >> j;
        logic [CNT-1:0]       v;
        logic [CNT*IDX_W-1:0] ix;

        if (j == 0) begin : g_leaf
            for (genvar l = 0; l < CNT; l++) begin : g_slot
                if (l < N_LANES) begin : g_real
                    assign v[l]                = ord_valid_i[l];
                    assign ix[l*IDX_W +: IDX_W] = ord_idx_i[l*IDX_W +: IDX_W];
                end else begin : g_pad
                    assign v[l]                = 1'b0;
                    assign ix[l*IDX_W +: IDX_W] = '0;
                end
            end
        end else begin : g_node
            for (genvar m = 0; m < CNT; m++) begin : g_pair
                ps_merge_node #(.IDX_W(IDX_W)) u_node (
                    .hi_valid_i (g_lvl[j-1].v[2*m]),
                    .hi_idx_i   (g_lvl[j-1].ix[(2*m)*IDX_W +: IDX_W]),
                    .lo_valid_i (g_lvl[j-1].v[2*m+1]),
                    .lo_idx_i   (g_lvl[j-1].ix[(2*m+1)*IDX_W +: IDX_W]),
                    .out_valid_o(v[m]),
                    .out_idx_o  (ix[m*IDX_W +: IDX_W])
                );
            end
        end
    end

    assign root_valid_o = g_lvl[LEVELS].v[0];
    assign root_idx_o   = g_lvl[LEVELS].ix[IDX_W-1:0];
endmodule

// File: rtl/ps_onehot_decode.sv
module ps_onehot_decode #(
    parameter int IDX_W = 4,
    localparam int OUT_W = 1 << IDX_W
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [OUT_W-1:0] onehot_o
);
    logic [OUT_W-1:0] term_d;
    logic [OUT_W-1:0] next_d;

    // Start from the enable; each index bit doubles the populated terms.
    always_comb begin
        term_d    = '0;
        term_d[0] = en_i;
        for (int b = 0; b < IDX_W; b++) begin
            next_d = '0;
            for (int g = 0; g < (1 << b); g++) begin
                next_d[g]            = term_d[g] & ~idx_i[b];
                next_d[g + (1 << b)] = term_d[g] &  idx_i[b];
            end
            term_d = next_d;
        end
        onehot_o = term_d;
    end
endmodule

// File: rtl/prio_onehot_scatter.sv
module prio_onehot_scatter
    import prio_scatter_pkg::*;
#(
    parameter int N_LANES    = 8,
    parameter int OUT_W      = 16,
    parameter int LANE_W     = 6,
    parameter int FIELD_LO   = 1,
    parameter bit HIGH_FIRST = 1'b0,
    localparam int IDX_W     = tree_levels(OUT_W)
) (
    input  logic [N_LANES-1:0]        valid_i,
    input  logic [N_LANES*LANE_W-1:0] data_i,
    output logic [OUT_W-1:0]          onehot_o
);
    logic [N_LANES-1:0]       ord_valid;
    logic [N_LANES*IDX_W-1:0] ord_idx;
    logic                     root_valid;
    logic [IDX_W-1:0]         root_idx;

    ps_lane_unpack #(
        .N_LANES   (N_LANES),
        .LANE_W    (LANE_W),
        .FIELD_LO  (FIELD_LO),
        .IDX_W     (IDX_W),
        .HIGH_FIRST(HIGH_FIRST)
    ) u_unpack (
        .valid_i    (valid_i),
        .data_i     (data_i),
        .ord_valid_o(ord_valid),
        .ord_idx_o  (ord_idx)
    );

    ps_merge_tree #(
        .N_LANES(N_LANES),
        .IDX_W  (IDX_W)
    ) u_tree (
        .ord_valid_i (ord_valid),
        .ord_idx_i   (ord_idx),
        .root_valid_o(root_valid),
        .root_idx_o  (root_idx)
    );

    ps_onehot_decode #(
        .IDX_W(IDX_W)
    ) u_decode (
        .en_i    (root_valid),
        .idx_i   (root_idx),
        .onehot_o(onehot_o)
    );
endmodule

// File: rtl/ps_checker.sv
module ps_checker #(
    parameter int N_LANES    = 8,
    parameter int OUT_W      = 16,
    parameter int LANE_W     = 6,
    parameter int FIELD_LO   = 1,
    parameter bit HIGH_FIRST = 1'b0
) (
    input logic [N_LANES-1:0]        valid_i,
    input logic [N_LANES*LANE_W-1:0] data_i,
    input logic [OUT_W-1:0]          onehot_o
);
    localparam int IDX_W = $clog2(OUT_W);

    int lo_lane;
    int hi_lane;
    int lo_pos;
    int hi_pos;

    always_comb begin
        lo_lane = -1;
        hi_lane = -1;
        for (int k = N_LANES - 1; k >= 0; k--)
            if (valid_i[k]) lo_lane = k;
        for (int k = 0; k < N_LANES; k++)
            if (valid_i[k]) hi_lane = k;
        lo_pos = (lo_lane < 0) ? 0 : int'(data_i[lo_lane*LANE_W + FIELD_LO +: IDX_W]);
        hi_pos = (hi_lane < 0) ? 0 : int'(data_i[hi_lane*LANE_W + FIELD_LO +: IDX_W]);

        AST_IDLE_ZERO: assert (valid_i != '0 || onehot_o == '0); // R1
        AST_SINGLE_HOT: assert (valid_i == '0 || $onehot(onehot_o)); // R2
        if (!HIGH_FIRST && lo_lane >= 0) begin
            AST_LOW_WINS: assert (onehot_o[lo_pos]); // R3
        end
        if (HIGH_FIRST && hi_lane >= 0) begin
            AST_HIGH_WINS: assert (onehot_o[hi_pos]); // R4
        end
    end
endmodule

bind prio_onehot_scatter ps_checker #(
    .N_LANES   (N_LANES),
    .OUT_W     (OUT_W),
    .LANE_W    (LANE_W),
    .FIELD_LO  (FIELD_LO),
    .HIGH_FIRST(HIGH_FIRST)
) u_ps_checker (
    .valid_i (valid_i),
    .data_i  (data_i),
    .onehot_o(onehot_o)
);

// File: tb/test_prio_onehot_scatter.sv
module test_prio_onehot_scatter;
    // Config A: 8 lanes, 16 outputs, 6-bit words, field at bit 1, low first.
    localparam int AN = 8, AW = 16, AS = 6, AL = 1, AI = 4;
    // Config B: 5 lanes, 8 outputs, packed 3-bit words, high first.
    localparam int BN = 5, BW = 8, BS = 3, BL = 0, BI = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [AN-1:0]    va;
    logic [AN*AS-1:0] da;
    logic [AW-1:0]    oa;
    logic [BN-1:0]    vb;
    logic [BN*BS-1:0] db;
    logic [BW-1:0]    ob;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    prio_onehot_scatter #(.N_LANES(AN), .OUT_W(AW), .LANE_W(AS), .FIELD_LO(AL), .HIGH_FIRST(1'b0))
        i_prio_onehot_scatter (.valid_i(va), .data_i(da), .onehot_o(oa));
    prio_onehot_scatter #(.N_LANES(BN), .OUT_W(BW), .LANE_W(BS), .FIELD_LO(BL), .HIGH_FIRST(1'b1))
        i_prio_onehot_scatter_hi (.valid_i(vb), .data_i(db), .onehot_o(ob));

    function automatic logic [63:0] model(input logic [63:0] v, input logic [511:0] d,
                                          input int n, input int s, input int lo,
                                          input int iw, input bit high);
        int win = -1;
        logic [511:0] sh;
        if (high) begin
            for (int k = 0; k < n; k++) if (v[k]) win = k;
        end else begin
            for (int k = n - 1; k >= 0; k--) if (v[k]) win = k;
        end
        if (win < 0) return 64'd0;
        sh = d >> (win * s + lo);
        return 64'd1 << (sh[5:0] & ((6'd1 << iw) - 6'd1));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both configs after a rising edge, compare 2 ns later (no edge there).
    task automatic apply(input string req, input logic [AN-1:0] nva, input logic [AN*AS-1:0] nda,
                         input logic [BN-1:0] nvb, input logic [BN*BS-1:0] ndb);
        @(posedge clk);
        va = nva; da = nda; vb = nvb; db = ndb;
        #2;
        check({req, " cfgA"}, 64'(oa), model(64'(nva), 512'(nda), AN, AS, AL, AI, 1'b0));
        check({req, " cfgB"}, 64'(ob), model(64'(nvb), 512'(ndb), BN, BS, BL, BI, 1'b1));
    endtask

    function automatic logic [AN*AS-1:0] rnd_a();
        return {$urandom, $urandom};
    endfunction
    function automatic logic [BN*BS-1:0] rnd_b();
        return BN*BS'($urandom);
    endfunction

    // Distinct, lane-dependent fields for both configs.
    function automatic logic [AN*AS-1:0] seq_a(input int mul, input int add);
        logic [AN*AS-1:0] d = '0;
        for (int k = 0; k < AN; k++) d[k*AS + AL +: AI] = AI'((k * mul + add) % AW);
        return d;
    endfunction
    function automatic logic [BN*BS-1:0] seq_b(input int mul, input int add);
        logic [BN*BS-1:0] d = '0;
        for (int k = 0; k < BN; k++) d[k*BS + BL +: BI] = BI'((k * mul + add) % BW);
        return d;
    endfunction

    initial begin
        logic [AW-1:0] keep_a;
        logic [BW-1:0] keep_b;
        logic [AN*AS-1:0] ta;
        logic [BN*BS-1:0] tb;
        void'($urandom(32'h5eed_0042));
        va = '0; da = '0; vb = '0; db = '0;
        #1;
        // Reset-like idle state: nothing requests.
        check("R1 idle at start cfgA", 64'(oa), 64'd0);
        check("R1 idle at start cfgB", 64'(ob), 64'd0);
        apply("R1 all invalid, busy data", '0, '1, '0, '1);

        for (int k = 0; k < AN; k++) begin
            apply("R5 single lane", AN'(1) << k, seq_a(3, 1), BN'(1) << (k % BN), seq_b(3, 1));
            apply("R2 single lane random", AN'(1) << k, rnd_a(), BN'(1) << (k % BN), rnd_b());
        end
        apply("R3 R4 all valid", '1, seq_a(1, 0), '1, seq_b(1, 0));
        apply("R3 R4 all valid reversed", '1, seq_a(AW - 1, 5), '1, seq_b(BW - 1, 2));

        for (int k = 0; k < AN; k++)
            apply("R3 prefix mask", '1 << k, seq_a(5, 2), BN'('1) << (k % BN), seq_b(5, 2));
        for (int k = 0; k < AN; k++)
            apply("R4 suffix mask", '1 >> (AN - 1 - k), seq_a(7, 3),
                  BN'('1) >> (BN - 1 - (k % BN)), seq_b(7, 3));
        for (int k = 0; k + 1 < AN; k++)
            apply("R8 adjacent pair", AN'(3) << k, seq_a(2, k + 1), BN'(3) << (k % (BN - 1)), seq_b(5, k));

        // R6: winner fixed, change loser words and non-field bits of the winner.
        for (int r = 0; r < 6; r++) begin
            ta = rnd_a();
            tb = rnd_b();
            apply("R6 base", AN'(5) << 1, ta, BN'(9), tb);
            keep_a = oa;
            keep_b = ob;
            for (int k = 0; k < AN; k++) if (k != 1) ta[k*AS +: AS] = AS'($urandom);
            ta[1*AS]          = ~ta[1*AS];
            ta[1*AS + AS - 1] = ~ta[1*AS + AS - 1];
            for (int k = 0; k < BN; k++) if (k != 3) tb[k*BS +: BS] = BS'($urandom);
            apply("R6 perturbed", AN'(5) << 1, ta, BN'(9), tb);
            check("R6 unchanged cfgA", 64'(oa), 64'(keep_a));
            check("R6 unchanged cfgB", 64'(ob), 64'(keep_b));
        end

        // R7: a change between clock edges is reflected without an edge.
        @(negedge clk);
        #1;
        va = AN'(8); da = seq_a(1, 9);
        vb = BN'(2); db = seq_b(1, 6);
        #1;
        check("R7 no edge cfgA", 64'(oa), model(64'(va), 512'(da), AN, AS, AL, AI, 1'b0));
        check("R7 no edge cfgB", 64'(ob), model(64'(vb), 512'(db), BN, BS, BL, BI, 1'b1));

        for (int r = 0; r < 2000; r++)
            apply("R2 R3 R4 R5 random", AN'($urandom) & AN'($urandom), rnd_a(),
                  BN'($urandom) & BN'($urandom), rnd_b());

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule